// File: doc/BRIEF.md
# Cover-Coded Password Check Unit

This unit guards the 16-bit words that a reader sends to a tag inside write, kill and access commands. Each time the reader requests a new random number, the unit draws a fresh 16-bit value from an internal linear-feedback shift register. It keeps that value as a one-time pad and presents it on its outputs so that it can be backscattered. The next protected word arrives as ciphertext. The unit recovers the plaintext by XOR with the held pad, and the pad is then spent.

A 32-bit kill or access password is entered in two steps: the upper half first, then the lower half. Each half is covered by its own freshly requested pad. The unit assembles the two halves and compares the result with the stored password, which comes from input ports. It reports the result as a one-cycle pass or fail pulse.

A half that arrives on a spent pad, or out of order, raises a sequence-error pulse and discards any partial password. After a failed comparison the unit ignores password halves until the reader requests a new random number. Ordinary write-data words are decoded and passed on with a valid strobe. Command parsing and nonvolatile storage are outside this block.

Top module: `pwcover_unit`

## Requirements
- R1: After reset, `rn_valid`, `data_valid`, `pw_pass`, `pw_fail` and `seq_err` are low and `rn_out` is zero.
- R2: A request pulse on `rn_req` produces `rn_valid` high in the next cycle, with `rn_out` holding the next value of a right-shifting Galois LFSR. The register is seeded with 16'hACE1 and steps as `s = s[0] ? (s>>1)^16'hB400 : s>>1`. `rn_out` keeps that value until the next request.
- R3: A word with `wd_pw`=0 that arrives while the pad is unspent gives `data_valid` high one cycle later, with `data_plain` equal to `wd_cipher` XOR the latest `rn_out`. The pad is then spent.
- R4: Any word that arrives after the pad has been spent, with no `rn_req` in between, gives `seq_err` one cycle later. It produces no data or password result and discards a partially assembled password. The only exception is a password half that is ignored under R9.
- R5: Password halves use `wd_pw`=1, with `wd_kill` (1 for the kill password, 0 for the access password) and `wd_lower` (0 for the upper half, 1 for the lower half). An upper half followed by a lower half of the same kind, each on a fresh pad, gives `pw_pass` one cycle after the lower half when the assembled value {upper, lower} equals the stored password.
- R6: A kill password is accepted only when the stored `kill_pw` is nonzero. If it is zero, the comparison reports `pw_fail` even when the assembled value is zero.
- R7: A mismatch gives `pw_fail` one cycle after the lower half. Alongside `pw_pass` or `pw_fail`, `pw_is_kill` reports which password was checked.
- R8: Each of the following gives `seq_err` and discards the partial password: a lower half with no upper half pending, an upper half while one is already pending, or a lower half whose kind differs from the pending upper half.
- R9: After `pw_fail`, password halves produce no output at all until an `rn_req` arrives. Write-data words are still handled as in R3 and R4.
- R10: At most one of `data_valid`, `pw_pass`, `pw_fail` and `seq_err` is high in any cycle, and each is a single-cycle pulse per input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_req | input | 1 | Request for a fresh random pad |
| wd_valid | input | 1 | Ciphertext word present |
| wd_pw | input | 1 | 1 = password half, 0 = write data |
| wd_kill | input | 1 | 1 = kill password, 0 = access password |
| wd_lower | input | 1 | 1 = lower half, 0 = upper half |
| wd_cipher | input | 16 | Covered word |
| kill_pw | input | 32 | Stored kill password |
| acc_pw | input | 32 | Stored access password |
| rn_valid | output | 1 | New pad issued this cycle |
| rn_out | output | 16 | Latest issued pad |
| data_valid | output | 1 | Decoded write word valid |
| data_plain | output | 16 | Decoded write word |
| pw_pass | output | 1 | Password accepted |
| pw_fail | output | 1 | Password rejected |
| pw_is_kill | output | 1 | Kind of the password just checked |
| seq_err | output | 1 | Stale pad or out-of-order half |

## Verification
The assertions assume that `rn_req` and `wd_valid` are never high in the same cycle. They also assume that the stored passwords do not change in the cycle a lower half arrives. The bench drives only one command per cycle and sets the stored passwords while the unit is between sequences. The bench model follows the same step-by-step pad and assembly rules and compares every output on every cycle. Directed sequences cover the stale-pad, ordering, zero-kill and lockout cases, and a long pseudo-random mix of requests and words follows them.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   localparam int unsigned PWC_HALF_W = 16;
   localparam logic [PWC_HALF_W-1:0] PWC_DEF_TAPS = 16'hB400;
   localparam logic [PWC_HALF_W-1:0] PWC_DEF_SEED = 16'hACE1;

   // Classification of an incoming covered word
   typedef struct packed {
      logic is_pw;
      logic is_kill;
      logic is_lower;
   } pwc_tag_t;
endpackage

// File: rtl/pwc_lfsr.sv
module pwc_lfsr #(
   parameter int unsigned W      = 16,
   parameter logic [W-1:0] TAPS  = 16'hB400,
   parameter logic [W-1:0] SEED  = 16'hACE1,
   parameter bit          GALOIS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] nxt
);
   logic [W-1:0] st;

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("pwc_lfsr: SEED must be nonzero");
      end
      if (W < 4) begin : g_bad_w
         $error("pwc_lfsr: W too small");
      end
      if (GALOIS) begin : g_galois
         always_comb nxt = st[0] ? ((st >> 1) ^ TAPS) : (st >> 1);
      end else begin : g_fib
         logic fb;
         always_comb begin
            fb  = ^(st & TAPS);
            nxt = {st[W-2:0], fb};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= SEED;
      else if (adv) st <= nxt;
   end

   p_never_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> st != '0);
endmodule

// File: rtl/pwc_pad.sv
module pwc_pad #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         consume,
   input  logic [W-1:0] cipher,
   output logic [W-1:0] pad,
   output logic         fresh,
   output logic [W-1:0] plain
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pad   <= '0;
         fresh <= 1'b0;
      end else if (load) begin
         pad   <= load_val;
         fresh <= 1'b1;
      end else if (consume) begin
         fresh <= 1'b0;
      end
   end

   always_comb plain = cipher ^ pad;

   p_load_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> fresh && pad == $past(load_val));
   p_spent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !load) |=> !fresh && $stable(pad));
endmodule

// File: rtl/pwc_seq.sv
module pwc_seq
   import pwc_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rn_req,
   input  logic           wd_valid,
   input  pwc_tag_t       tag,
   input  logic           fresh,
   input  logic [W-1:0]   plain,
   input  logic [2*W-1:0] kill_pw,
   input  logic [2*W-1:0] acc_pw,
   output logic           consume,
   output logic           data_valid,
   output logic [W-1:0]   data_plain,
   output logic           pw_pass,
   output logic           pw_fail,
   output logic           pw_is_kill,
   output logic           seq_err
);
   localparam int unsigned PW_W = 2 * W;

   logic           have_up;
   logic           up_kill;
   logic [W-1:0]   up_val;
   logic           locked;
   logic           ignore_w;
   logic [PW_W-1:0] full;
   logic [PW_W-1:0] stored;
   logic           match;

   always_comb begin
      ignore_w = tag.is_pw && locked;
      consume  = wd_valid && !rn_req && fresh && !ignore_w;
      full     = {up_val, plain};
      stored   = tag.is_kill ? kill_pw : acc_pw;
      match    = (full == stored) && (!tag.is_kill || (kill_pw != '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_up    <= 1'b0;
         up_kill    <= 1'b0;
         up_val     <= '0;
         locked     <= 1'b0;
         data_valid <= 1'b0;
         data_plain <= '0;
         pw_pass    <= 1'b0;
         pw_fail    <= 1'b0;
         pw_is_kill <= 1'b0;
         seq_err    <= 1'b0;
      end else begin
         data_valid <= 1'b0;
         pw_pass    <= 1'b0;
         pw_fail    <= 1'b0;
         seq_err    <= 1'b0;
         if (rn_req) begin
            locked <= 1'b0;
         end else if (wd_valid && !ignore_w) begin
            if (!fresh) begin
               seq_err <= 1'b1;
               have_up <= 1'b0;
            end else if (!tag.is_pw) begin
               data_valid <= 1'b1;
               data_plain <= plain;
            end else if (!tag.is_lower) begin
               if (have_up) begin
                  seq_err <= 1'b1;
                  have_up <= 1'b0;
               end else begin
                  have_up <= 1'b1;
                  up_kill <= tag.is_kill;
                  up_val  <= plain;
               end
            end else if (!have_up || (up_kill != tag.is_kill)) begin
               seq_err <= 1'b1;
               have_up <= 1'b0;
            end else begin
               have_up    <= 1'b0;
               pw_is_kill <= tag.is_kill;
               pw_pass    <= match;
               pw_fail    <= !match;
               locked     <= !match;
            end
         end
      end
   end

   p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_valid, pw_pass, pw_fail, seq_err}));
   p_kill_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_pass && pw_is_kill) |-> $past(kill_pw) != '0);
   p_fail_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pw_fail |-> locked);
   p_locked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !rn_req && wd_valid && tag.is_pw) |=> !(pw_pass || pw_fail || seq_err));
   p_stale_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_valid && !rn_req && !fresh && !(tag.is_pw && locked)) |=> seq_err);
endmodule

// File: rtl/pwcover_unit.sv
module pwcover_unit
   import pwc_pkg::*;
#(
   parameter int unsigned  W      = PWC_HALF_W,
   parameter logic [W-1:0] TAPS   = PWC_DEF_TAPS,
   parameter logic [W-1:0] SEED   = PWC_DEF_SEED,
   parameter bit           GALOIS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rn_req,
   input  logic             wd_valid,
   input  logic             wd_pw,
   input  logic             wd_kill,
   input  logic             wd_lower,
   input  logic [W-1:0]     wd_cipher,
   input  logic [2*W-1:0]   kill_pw,
   input  logic [2*W-1:0]   acc_pw,
   output logic             rn_valid,
   output logic [W-1:0]     rn_out,
   output logic             data_valid,
   output logic [W-1:0]     data_plain,
   output logic             pw_pass,
   output logic             pw_fail,
   output logic             pw_is_kill,
   output logic             seq_err
);
   logic [W-1:0] rn_nxt;
   logic [W-1:0] plain;
   logic         fresh;
   logic         consume;
   pwc_tag_t     tag;

   always_comb tag = '{is_pw: wd_pw, is_kill: wd_kill, is_lower: wd_lower};

   pwc_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED), .GALOIS(GALOIS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv(rn_req), .nxt(rn_nxt)
   );

   pwc_pad #(.W(W)) u_pad (
      .clk(clk), .rst_n(rst_n), .load(rn_req), .load_val(rn_nxt),
      .consume(consume), .cipher(wd_cipher), .pad(rn_out),
      .fresh(fresh), .plain(plain)
   );

   pwc_seq #(.W(W)) u_seq (
      .clk(clk), .rst_n(rst_n), .rn_req(rn_req), .wd_valid(wd_valid),
      .tag(tag), .fresh(fresh), .plain(plain), .kill_pw(kill_pw),
      .acc_pw(acc_pw), .consume(consume), .data_valid(data_valid),
      .data_plain(data_plain), .pw_pass(pw_pass), .pw_fail(pw_fail),
      .pw_is_kill(pw_is_kill), .seq_err(seq_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rn_valid <= 1'b0;
      else        rn_valid <= rn_req;
   end

   p_no_overlap_in: assert property (@(posedge clk) disable iff (!rst_n)
      !(rn_req && wd_valid));
   p_rn_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rn_req |=> rn_valid && rn_out != '0);
   p_rn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rn_req |=> $stable(rn_out));
endmodule

// File: tb/tb_pwcover_unit.sv
module tb_pwcover_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rn_req, wd_valid, wd_pw, wd_kill, wd_lower;
   logic [15:0] wd_cipher;
   logic [31:0] kill_pw, acc_pw;
   logic        rn_valid, data_valid, pw_pass, pw_fail, pw_is_kill, seq_err;
   logic [15:0] rn_out, data_plain;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   logic [15:0] m_lfsr, m_pad, m_up;
   bit          m_fresh, m_have, m_upk, m_lock;
   bit          e_rv, e_dv, e_pass, e_fail, e_err, e_kill;
   logic [15:0] e_rn, e_data;
   int unsigned lcg = 32'h1234_5678;

   always #10 clk = ~clk;

   pwcover_unit dut (
      .clk(clk), .rst_n(rst_n), .rn_req(rn_req), .wd_valid(wd_valid),
      .wd_pw(wd_pw), .wd_kill(wd_kill), .wd_lower(wd_lower),
      .wd_cipher(wd_cipher), .kill_pw(kill_pw), .acc_pw(acc_pw),
      .rn_valid(rn_valid), .rn_out(rn_out), .data_valid(data_valid),
      .data_plain(data_plain), .pw_pass(pw_pass), .pw_fail(pw_fail),
      .pw_is_kill(pw_is_kill), .seq_err(seq_err)
   );

   function automatic logic [15:0] lstep(input logic [15:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock of stimulus, reference update and comparison
   task automatic step(input bit rq, input bit wv, input bit pw, input bit kl,
                       input bit lo, input logic [15:0] cph);
      logic [15:0] pl;
      logic [31:0] full, stv;
      bit ok;
      rn_req = rq; wd_valid = wv; wd_pw = pw; wd_kill = kl;
      wd_lower = lo; wd_cipher = cph;
      e_rv = 0; e_dv = 0; e_pass = 0; e_fail = 0; e_err = 0;
      if (rq) begin
         m_lfsr = lstep(m_lfsr); m_pad = m_lfsr; m_fresh = 1;
         m_lock = 0; e_rv = 1; e_rn = m_lfsr;
      end else if (wv && !(pw && m_lock)) begin
         pl = cph ^ m_pad;
         if (!m_fresh) begin
            e_err = 1; m_have = 0;
         end else begin
            m_fresh = 0;
            if (!pw) begin
               e_dv = 1; e_data = pl;
            end else if (!lo) begin
               if (m_have) begin e_err = 1; m_have = 0; end
               else begin m_have = 1; m_upk = kl; m_up = pl; end
            end else if (!m_have || m_upk != kl) begin
               e_err = 1; m_have = 0;
            end else begin
               m_have = 0; full = {m_up, pl};
               stv = kl ? kill_pw : acc_pw;
               ok = (full == stv) && (!kl || kill_pw != 0);
               e_pass = ok; e_fail = !ok; e_kill = kl;
               if (!ok) m_lock = 1;
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
      rn_req = 0; wd_valid = 0;
      chk("R2 rn_valid", rn_valid, e_rv);
      chk("R2 rn_out", rn_out, e_rn);
      chk("R3 data_valid", data_valid, e_dv);
      if (e_dv) chk("R3 data_plain", data_plain, e_data);
      chk("R4 seq_err", seq_err, e_err);
      chk("R5 pw_pass", pw_pass, e_pass);
      chk("R7 pw_fail", pw_fail, e_fail);
      if (e_pass || e_fail) chk("R7 pw_is_kill", pw_is_kill, e_kill);
      chk("R10 onehot", int'(data_valid) + int'(pw_pass) + int'(pw_fail) + int'(seq_err) <= 1, 1);
   endtask

   task automatic req();
      step(1, 0, 0, 0, 0, 16'h0);
   endtask

   task automatic half(input bit kl, input bit lo, input logic [15:0] p);
      step(0, 1, 1, kl, lo, p ^ m_pad);
   endtask

   task automatic send_pw(input bit kl, input logic [31:0] v);
      req(); half(kl, 0, v[31:16]);
      req(); half(kl, 1, v[15:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; rn_req = 0; wd_valid = 0; wd_pw = 0; wd_kill = 0;
      wd_lower = 0; wd_cipher = 0;
      kill_pw = 32'hDEAD_BEEF; acc_pw = 32'h1357_9BDF;
      m_lfsr = 16'hACE1; m_pad = 0; m_up = 0; m_fresh = 0; m_have = 0;
      m_upk = 0; m_lock = 0; e_rn = 0; e_data = 0; e_kill = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 rn_valid", rn_valid, 0);
      chk("R1 rn_out", rn_out, 0);
      chk("R1 results", {data_valid, pw_pass, pw_fail, seq_err}, 0);

      // R2/R3: pads and decoded write data
      req(); req(); req();
      step(0, 1, 0, 0, 0, 16'hA5A5 ^ m_pad);
      req(); step(0, 1, 0, 0, 0, 16'h0000 ^ m_pad);
      // R4: stale pad on write data
      step(0, 1, 0, 0, 0, 16'h1111);
      // R5: access and kill passwords accepted
      send_pw(0, 32'h1357_9BDF);
      send_pw(1, 32'hDEAD_BEEF);
      // R7 then R9: wrong kill, halves ignored, data still handled
      send_pw(1, 32'hDEAD_BEEE);
      half(1, 0, 16'hDEAD);
      chk("R9 locked half ignored", {pw_pass, pw_fail, seq_err}, 0);
      half(0, 1, 16'h9BDF);
      step(0, 1, 0, 0, 0, 16'h2222);
      chk("R9 data still seen as stale", seq_err, 1);
      send_pw(1, 32'hDEAD_BEEF);
      // R6: zero stored kill password never accepted
      kill_pw = 32'h0;
      send_pw(1, 32'h0);
      chk("R6 zero kill rejected", pw_fail, 1);
      kill_pw = 32'hDEAD_BEEF;
      // R4: second half on a spent pad
      req(); half(0, 0, 16'h1357); half(0, 1, 16'h9BDF);
      // R8: ordering errors
      req(); half(0, 1, 16'h9BDF);
      chk("R8 lower first", seq_err, 1);
      req(); half(0, 0, 16'h1357); req(); half(0, 0, 16'h1357);
      chk("R8 double upper", seq_err, 1);
      req(); half(0, 0, 16'h1357); req(); half(1, 1, 16'h9BDF);
      chk("R8 kind change", seq_err, 1);
      send_pw(0, 32'h1357_9BDF);
      chk("R5 recovery pass", pw_pass, 1);

      // mixed pseudo-random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] v;
         lcg = lcg * 1103515245 + 12345;
         v = lcg[30:15];
         case (lcg[4:2])
            3'd0, 3'd1: req();
            3'd2: step(0, 1, 0, 0, 0, v);
            3'd3: half(lcg[5], lcg[6], lcg[7] ? acc_pw[31:16] : v);
            3'd4: half(lcg[5], 1'b1, lcg[7] ? (lcg[5] ? kill_pw[15:0] : acc_pw[15:0]) : v);
            3'd5: half(lcg[5], 1'b0, lcg[5] ? kill_pw[31:16] : acc_pw[31:16]);
            3'd6: send_pw(lcg[5], lcg[7] ? (lcg[5] ? kill_pw : acc_pw) : {v, v});
            default: step(0, 0, 0, 0, 0, v);
         endcase
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule